// File: doc/BRIEF.md
# Reservation-Table Initiation Controller

This block decides, cycle by cycle, whether a new task may enter a dynamic pipeline whose stages can each be claimed in several cycles of one task's passage. The usage pattern is held in a programmable table: one row per stage, one bit per cycle after initiation. From that table the block works out which initiation spacings would make two tasks claim the same stage in the same cycle. It then grants a pending request only when the spacing to every task still in flight is safe.

A requester raises `init_req` and holds it. The controller answers on `init_gnt` in the same cycle when the task may start. A request that cannot start yet simply waits; it is granted at the first safe spacing. The table is written one row at a time through a small write port, and a write is taken only while no task is in flight. For checking, the block reports each cycle which stages are occupied by tasks already started, including one granted in that same cycle.

Internally a shifting collision vector holds the spacings that are currently unsafe. Bit 0 stands for "starting now would collide". On every grant the table's initial collision vector is merged into the shifted vector.

Top module: `rtp_init_ctrl`

## Requirements
- R1: After reset the table is empty, no stage is reported busy, `init_gnt` is low while `init_req` is low, and with the empty table every request is granted in the cycle it is raised.
- R2: A spacing of d cycles (1 <= d < CYCLES) is unsafe exactly when some row of the table holds two marks d columns apart. The unsafe set is the union over all rows.
- R3: `init_gnt` is high only in a cycle where `init_req` is high. It is never high in a cycle where starting would put the new task an unsafe spacing after any task in flight.
- R4: A request held high is granted in the first cycle whose spacing to every task in flight is safe. Each grant adds that task's unsafe spacings to the ones already pending.
- R5: With no request, pending unsafe spacings age by one per cycle. Once CYCLES-1 cycles pass without a grant, any request is granted.
- R6: No two started tasks ever claim the same stage in the same cycle.
- R7: `stage_busy[s]` is high in a cycle exactly when some task started a cycles earlier (a = 0 for a grant in the current cycle, a < CYCLES) has row s, bit a set in the table.
- R8: A row write (`tbl_we` high, `tbl_stage` selects the row, `tbl_row` bit c marks the stage as used c cycles after initiation) is taken only when no task started within the last CYCLES-1 cycles. Otherwise it is dropped and the table is unchanged.
- R9: No grant is given in a cycle where `tbl_we` is high, nor in the cycle after a taken write, while the unsafe set is recomputed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| init_req | input | 1 | Request to start a task; held until granted |
| init_gnt | output | 1 | Task starts in this cycle |
| tbl_we | input | 1 | Table row write strobe |
| tbl_stage | input | SW | Row (stage) index to write |
| tbl_row | input | CYCLES | Row contents, bit c = stage used c cycles after initiation |
| stage_busy | output | STAGES | Stages occupied this cycle by started tasks |

## Verification
The admission logic is driven with four tables: a single-stage row with three adjacent marks, rows whose mark distances give scattered unsafe spacings, a row pair that bans the longest spacing, and a diagonal table with no unsafe spacing at all. Each table is exercised with a request held high, a request that toggles every cycle and a request pattern with idle gaps. The held request shows where the first safe spacing lies. The toggling and gapped patterns show that pending unsafe spacings age correctly across cycles without grants, and that they combine over several tasks in flight. Directed cases then write a row while a task is in flight to show the write is dropped, and they request during and just after a write to show the recompute blackout.

// File: rtl/rtp_pkg.sv
package rtp_pkg;
  localparam int DEF_STAGES = 8;
  localparam int DEF_CYCLES = 8;

  function automatic int idx_w(input int n);
    return (n > 1) ? $clog2(n) : 1;
  endfunction
endpackage

// File: rtl/rtp_table.sv
module rtp_table #(
  parameter int STAGES = rtp_pkg::DEF_STAGES,
  parameter int CYCLES = rtp_pkg::DEF_CYCLES,
  localparam int SW    = rtp_pkg::idx_w(STAGES),
  localparam int LW    = CYCLES - 1
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic                           wr_en,
  input  logic [SW-1:0]                  wr_stage,
  input  logic [CYCLES-1:0]              wr_row,
  input  logic                           wr_allow,
  output logic [STAGES-1:0][CYCLES-1:0]  tbl_q,
  output logic [LW-1:0]                  icv_q,
  output logic                           stale_q,
  output logic                           wr_taken
);
  // unsafe spacings of one row: distance between any two marks
  function automatic logic [LW-1:0] row_forbid(input logic [CYCLES-1:0] row);
    logic [LW-1:0] m;
    m = '0;
    for (int a = 0; a < CYCLES; a++)
      for (int b = a + 1; b < CYCLES; b++)
        if (row[a] && row[b]) m[b-a-1] = 1'b1;
    return m;
  endfunction

  function automatic logic [LW-1:0] table_forbid(input logic [STAGES-1:0][CYCLES-1:0] t);
    logic [LW-1:0] m;
    m = '0;
    for (int s = 0; s < STAGES; s++) m = m | row_forbid(t[s]);
    return m;
  endfunction

  assign wr_taken = wr_en & wr_allow;

  for (genvar s = 0; s < STAGES; s++) begin : g_row
    always_ff @(posedge clk) begin
      if (!rst_n)
        tbl_q[s] <= '0;
      else if (wr_taken && (wr_stage == SW'(s)))
        tbl_q[s] <= wr_row;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      icv_q   <= '0;
      stale_q <= 1'b0;
    end else begin
      icv_q   <= table_forbid(tbl_q);
      stale_q <= wr_taken;
    end
  end
endmodule

// File: rtl/rtp_cvec.sv
module rtp_cvec #(
  parameter int CYCLES = rtp_pkg::DEF_CYCLES,
  localparam int LW    = CYCLES - 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req,
  input  logic          hold,
  input  logic [LW-1:0] icv,
  output logic          gnt,
  output logic          head_blocked,
  output logic [LW-1:0] cv_q
);
  function automatic logic [LW-1:0] advance(input logic [LW-1:0] cv,
                                            input logic          take,
                                            input logic [LW-1:0] init);
    logic [LW-1:0] sh;
    sh = cv >> 1;
    return take ? (sh | init) : sh;
  endfunction

  assign head_blocked = cv_q[0];
  assign gnt          = req & ~hold & ~head_blocked;

  always_ff @(posedge clk) begin
    if (!rst_n) cv_q <= '0;
    else        cv_q <= advance(cv_q, gnt, icv);
  end
endmodule

// File: rtl/rtp_track.sv
module rtp_track #(
  parameter int STAGES = rtp_pkg::DEF_STAGES,
  parameter int CYCLES = rtp_pkg::DEF_CYCLES,
  localparam int HW    = CYCLES - 1
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          gnt,
  input  logic [STAGES-1:0][CYCLES-1:0] tbl,
  output logic [STAGES-1:0]             busy,
  output logic                          idle,
  output logic                          collision
);
  logic [HW-1:0]     hist_q;  // bit k: task started k+1 cycles ago
  logic [CYCLES-1:0] age;     // bit a: task started a cycles ago
  logic [STAGES-1:0] over;

  assign age  = {hist_q, gnt};
  assign idle = ~|hist_q;

  always_ff @(posedge clk) begin
    if (!rst_n) hist_q <= '0;
    else        hist_q <= (hist_q << 1) | HW'(gnt);
  end

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    assign busy[s] = |(age & tbl[s]);
    assign over[s] = $countones(age & tbl[s]) > 1;
  end

  assign collision = |over;
endmodule

// File: rtl/rtp_init_ctrl.sv
module rtp_init_ctrl #(
  parameter int STAGES = rtp_pkg::DEF_STAGES,
  parameter int CYCLES = rtp_pkg::DEF_CYCLES,
  localparam int SW    = rtp_pkg::idx_w(STAGES),
  localparam int LW    = CYCLES - 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              init_req,
  output logic              init_gnt,
  input  logic              tbl_we,
  input  logic [SW-1:0]     tbl_stage,
  input  logic [CYCLES-1:0] tbl_row,
  output logic [STAGES-1:0] stage_busy
);
  logic [STAGES-1:0][CYCLES-1:0] tbl_q;
  logic [LW-1:0]                 icv_q;
  logic [LW-1:0]                 cv_q;
  logic                          stale_q;
  logic                          wr_taken;
  logic                          idle;
  logic                          hold;
  logic                          head_blocked;
  logic                          collision;

  assign hold = tbl_we | stale_q;

  rtp_table #(.STAGES(STAGES), .CYCLES(CYCLES)) u_table (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en    (tbl_we),
    .wr_stage (tbl_stage),
    .wr_row   (tbl_row),
    .wr_allow (idle),
    .tbl_q    (tbl_q),
    .icv_q    (icv_q),
    .stale_q  (stale_q),
    .wr_taken (wr_taken)
  );

  rtp_cvec #(.CYCLES(CYCLES)) u_cvec (
    .clk          (clk),
    .rst_n        (rst_n),
    .req          (init_req),
    .hold         (hold),
    .icv          (icv_q),
    .gnt          (init_gnt),
    .head_blocked (head_blocked),
    .cv_q         (cv_q)
  );

  rtp_track #(.STAGES(STAGES), .CYCLES(CYCLES)) u_track (
    .clk       (clk),
    .rst_n     (rst_n),
    .gnt       (init_gnt),
    .tbl       (tbl_q),
    .busy      (stage_busy),
    .idle      (idle),
    .collision (collision)
  );
endmodule

// File: rtl/rtp_init_ctrl_chk.sv
module rtp_init_ctrl_chk #(
  parameter int STAGES = rtp_pkg::DEF_STAGES,
  parameter int CYCLES = rtp_pkg::DEF_CYCLES
) (
  input logic                          clk,
  input logic                          rst_n,
  input logic                          init_req,
  input logic                          init_gnt,
  input logic                          tbl_we,
  input logic                          stale_q,
  input logic                          idle,
  input logic                          collision,
  input logic [STAGES-1:0]             stage_busy,
  input logic [STAGES-1:0][CYCLES-1:0] tbl_q
);
  assert_grant_needs_req_R3: assert property (@(posedge clk) disable iff (!rst_n)
    init_gnt |-> init_req);

  assert_no_collision_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !collision);

  assert_no_grant_on_write_R9: assert property (@(posedge clk) disable iff (!rst_n)
    tbl_we |-> !init_gnt);

  assert_no_grant_after_write_R9: assert property (@(posedge clk) disable iff (!rst_n)
    stale_q |-> !init_gnt);

  assert_busy_write_dropped_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (tbl_we && !idle) |=> $stable(tbl_q));

  assert_quiet_when_idle_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (idle && !init_gnt) |-> (stage_busy == '0));
endmodule

bind rtp_init_ctrl rtp_init_ctrl_chk #(.STAGES(STAGES), .CYCLES(CYCLES)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .init_req   (init_req),
  .init_gnt   (init_gnt),
  .tbl_we     (tbl_we),
  .stale_q    (stale_q),
  .idle       (idle),
  .collision  (collision),
  .stage_busy (stage_busy),
  .tbl_q      (tbl_q)
);

// File: tb/sim_rtp_init_ctrl.sv
`timescale 1ns/1ps
module sim_rtp_init_ctrl;
  localparam int ST = 8;
  localparam int CY = 8;

  typedef struct packed {
    logic [63:0] tbl;   // byte s = row of stage s, bit c = cycle c
    logic [6:0]  forb;  // bit d-1 = spacing d unsafe
    logic [31:0] req;   // bit t = request in cycle t
  } vec_t;

  localparam vec_t VEC [8] = '{
    '{64'h0000_0000_0084_0A21, 7'h12, 32'hFFFF_FFFF},
    '{64'h0000_0000_0084_0A21, 7'h12, 32'h5555_5555},
    '{64'h0000_0000_0000_0807, 7'h03, 32'hFFFF_FFFF},
    '{64'h0000_0000_0000_0807, 7'h03, 32'hF0F0_3C3C},
    '{64'h0000_0000_5400_0081, 7'h4A, 32'hFFFF_FFFF},
    '{64'h0000_0000_5400_0081, 7'h4A, 32'h8181_E00F},
    '{64'h8040_2010_0804_0201, 7'h00, 32'hFFFF_FFFF},
    '{64'h8040_2010_0804_0201, 7'h00, 32'hA5A5_0FF0}
  };

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          init_req = 1'b0;
  logic          init_gnt;
  logic          tbl_we = 1'b0;
  logic [2:0]    tbl_stage = '0;
  logic [7:0]    tbl_row = '0;
  logic [ST-1:0] stage_busy;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  logic [63:0] mtbl;
  logic [6:0]  mforb;
  logic [CY-1:0] mage;  // bit d: expected task started d cycles ago (d>=1)

  always #2.5 clk = ~clk;

  rtp_init_ctrl u0 (
    .clk(clk), .rst_n(rst_n), .init_req(init_req), .init_gnt(init_gnt),
    .tbl_we(tbl_we), .tbl_stage(tbl_stage), .tbl_row(tbl_row),
    .stage_busy(stage_busy)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [6:0] derive_forb(input logic [63:0] t);
    logic [6:0] f;
    f = '0;
    for (int d = 1; d < CY; d++)
      for (int s = 0; s < ST; s++)
        for (int c = 0; c + d < CY; c++)
          if (t[8*s+c] && t[8*s+c+d]) f[d-1] = 1'b1;
    return f;
  endfunction

  // one cycle: drive request, check grant and busy against the model
  task automatic step(input logic rq, input string tag);
    logic eg;
    logic [ST-1:0] eb;
    logic [CY-1:0] a;
    @(negedge clk);
    init_req = rq;
    #1;
    eg = rq;
    for (int d = 1; d < CY; d++)
      if (mage[d] && mforb[d-1]) eg = 1'b0;
    a = mage | CY'(eg);
    eb = '0;
    for (int s = 0; s < ST; s++)
      for (int d = 0; d < CY; d++)
        if (a[d] && mtbl[8*s+d]) eb[s] = 1'b1;
    check({tag, " gnt"}, 32'(init_gnt), 32'(eg));
    check({tag, " busy"}, 32'(stage_busy), 32'(eb));
    mage = a << 1;
  endtask

  task automatic quiet(input int n);
    for (int i = 0; i < n; i++) step(1'b0, "R5 idle");
  endtask

  task automatic load(input logic [63:0] t);
    for (int s = 0; s < ST; s++) begin
      @(negedge clk);
      init_req = 1'b0;
      tbl_we = 1'b1;
      tbl_stage = 3'(s);
      tbl_row = t[8*s +: 8];
    end
    @(negedge clk);
    tbl_we = 1'b0;
    mtbl = t;
  endtask

  initial begin
    mtbl = '0; mforb = '0; mage = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1: reset state and empty table
    @(negedge clk); #1;
    check("R1 gnt idle", 32'(init_gnt), 32'd0);
    check("R1 busy reset", 32'(stage_busy), 32'd0);
    for (int i = 0; i < 3; i++) step(1'b1, "R1 empty table");
    quiet(CY);

    // table-driven runs: R2 R3 R4 R5 R6 R7
    for (int v = 0; v < 8; v++) begin
      load(VEC[v].tbl);
      check("R2 vector forbidden set", 32'(derive_forb(VEC[v].tbl)), 32'(VEC[v].forb));
      mforb = VEC[v].forb;
      mage = '0;
      quiet(3);
      for (int t = 0; t < 32; t++) step(VEC[v].req[t], "R4 pattern");
      quiet(CY);
    end

    // R8: write while a task is in flight is dropped
    load(64'h0000_0000_0000_0807);
    mforb = 7'h03; mage = '0;
    quiet(3);
    step(1'b1, "R8 start");
    @(negedge clk);
    init_req = 1'b0; tbl_we = 1'b1; tbl_stage = 3'd0; tbl_row = 8'h01;
    #1;
    check("R9 gnt during write", 32'(init_gnt), 32'd0);
    mage = mage << 1;
    @(negedge clk);
    tbl_we = 1'b0;
    mage = mage << 1;
    quiet(CY);
    for (int i = 0; i < 4; i++) step(1'b1, "R8 table kept");
    quiet(CY);

    // R9: blackout on the write cycle and the one after
    @(negedge clk);
    tbl_we = 1'b1; tbl_stage = 3'd0; tbl_row = 8'h07; init_req = 1'b1;
    #1;
    check("R9 write cycle", 32'(init_gnt), 32'd0);
    @(negedge clk);
    tbl_we = 1'b0; init_req = 1'b1;
    #1;
    check("R9 recompute cycle", 32'(init_gnt), 32'd0);
    step(1'b1, "R9 after blackout");
    quiet(CY);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule